// File: doc/BRIEF.md
# Paged Receive Ring Buffer Controller

This block stores received frames in a circular region of a byte-wide buffer memory. The region is made of 256-byte pages, from a low page up to, but not including, a high page. Frame bytes arrive as a stream. Each frame is placed starting at byte offset 4 of the page named by the current-page pointer. The first four bytes of that page are kept for a descriptor: a status byte, a link to the page where the next frame will start, and the stored length as a low byte and a high byte. The descriptor is written only once the frame has ended, and the current-page pointer moves to the link value only after that.

A host drains the ring from behind and returns pages by moving a boundary pointer. The controller never writes a byte into the boundary page. If a frame reaches that page, the frame is abandoned, the current page keeps the value it had when the frame started, and a sticky overwrite warning is raised. Frames that arrive with an error flag are dropped in the same way, unless the keep-errored option is set.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, or for one cycle after `ring_init`, `cur_page` equals `page_lo`, `bnry_page` equals `page_hi - 1`, and `ovw_flag` is 0.
- R2: Payload byte k of a frame, counting from 0, is written to memory address `{P, 8'h00} + 4 + k`, where P is `cur_page` at the start of the frame. The high 8 bits of `mem_addr` are the page and the low 8 bits are the offset.
- R3: When a write passes offset 255 of page `page_hi - 1`, it continues at offset 0 of `page_lo`. A memory write never lands outside `[page_lo, page_hi)`.
- R4: A stored frame gets four descriptor writes at offsets 0, 1, 2 and 3 of its first page, in that order, on consecutive cycles. All four come after the frame's last payload byte.
- R5: Descriptor byte 2 holds the low byte and byte 3 the high byte of the stored length. The stored length is the number of stream bytes in the frame, with the 4 trailing CRC bytes included.
- R6: Descriptor byte 1 is the page that follows the last page the frame touched, wrapping to `page_lo`. `cur_page` takes this value only once the descriptor has been written, and it does not change otherwise, except on reset or init.
- R7: The status byte is laid out as follows: bit 0 is set when no error flag was raised, bit 1 reflects `rx_crc_bad`, bit 2 reflects `rx_align_bad`, bit 3 reflects `rx_fifo_ovr`, and bits 7:4 are 0.
- R8: With `keep_bad` = 0, a frame ending with any error flag gets no descriptor and leaves `cur_page` unchanged. With `keep_bad` = 1, the frame is stored like a good frame.
- R9: A byte whose page equals `bnry_page` is not written. Its frame gets no descriptor and `cur_page` keeps its value. `ovw_flag` becomes 1 and stays at 1 until `ovw_clr` is asserted.
- R10: A host write (`bnry_we`) loads `bnry_wdata` into `bnry_page` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_lo | input | 8 | First page of the ring |
| page_hi | input | 8 | Page just past the ring |
| ring_init | input | 1 | Reload the pointers to their initial values |
| keep_bad | input | 1 | Store frames that have error flags |
| bnry_we | input | 1 | Host boundary write strobe |
| bnry_wdata | input | 8 | New boundary page |
| ovw_clr | input | 1 | Clear the overwrite warning |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_bad | input | 1 | CRC error flag, sampled with rx_last |
| rx_align_bad | input | 1 | Alignment error flag, sampled with rx_last |
| rx_fifo_ovr | input | 1 | FIFO overrun flag, sampled with rx_last |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 16 | Buffer memory byte address {page, offset} |
| mem_wdata | output | 8 | Buffer memory write data |
| cur_page | output | 8 | Current page pointer |
| bnry_page | output | 8 | Boundary page pointer |
| ovw_flag | output | 1 | Sticky overwrite warning |

## Verification
The hardest case to reach is an overflow in the middle of a frame after the frame has already wrapped from the top page to the bottom page. To get there, the ring must first be nearly full and the boundary must sit just past the wrap point. The stimulus builds this up in steps. It stores frames until the current page meets the boundary. It then returns pages through host boundary writes chosen to leave exactly three free pages. Finally it sends a frame longer than those pages, so the write stream crosses the wrap and then stops at the boundary. An error frame that is dropped, an error frame that is kept, and an overflow on the very first byte are placed along the same path.

// File: rtl/rx_page_ring_pkg.sv
package rx_page_ring_pkg;

    localparam int PG_W   = 8;
    localparam int OFF_W  = 8;
    localparam int ADR_W  = PG_W + OFF_W;
    localparam int LEN_W  = 16;
    localparam int HDR_N  = 4;
    localparam int HIDX_W = $clog2(HDR_N);

    typedef logic [PG_W-1:0]  page_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_BODY,
        WR_SKIP,
        WR_HDR
    } wr_st_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       fifo_ovr;
        logic       align_bad;
        logic       crc_bad;
        logic       intact;
    } rx_stat_t;

    function automatic page_t page_after(page_t p, page_t lo, page_t hi);
        page_t n;
        n = p + page_t'(1);
        return (n == hi) ? lo : n;
    endfunction

endpackage

// File: rtl/rpr_ptrs.sv
module rpr_ptrs
    import rx_page_ring_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  page_t lo,
    input  page_t hi,
    input  logic  bnry_we,
    input  page_t bnry_wdata,
    input  logic  load,
    input  page_t load_val,
    input  logic  ovf_evt,
    input  logic  ovw_clr,
    output page_t cur_q,
    output page_t bnry_q,
    output logic  ovw_q
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cur_q  <= lo;
            bnry_q <= hi - page_t'(1);
            ovw_q  <= 1'b0;
        end else begin
            if (load)
                cur_q <= load_val;
            if (bnry_we)
                bnry_q <= bnry_wdata;
            if (ovf_evt)
                ovw_q <= 1'b1;
            else if (ovw_clr)
                ovw_q <= 1'b0;
        end
    end

    // R6
    cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !init) |=> $stable(cur_q));

    // R9
    ovw_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ovw_q && !ovw_clr && !init) |=> ovw_q);

    // R10
    bnry_take_chk: assert property (@(posedge clk) disable iff (rst)
        (bnry_we && !init) |=> (bnry_q == $past(bnry_wdata)));

endmodule

// File: rtl/rpr_writer.sv
module rpr_writer
    import rx_page_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  page_t             cur,
    input  page_t             bnry,
    input  page_t             lo,
    input  page_t             hi,
    input  logic              keep_bad,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_crc_bad,
    input  logic              rx_align_bad,
    input  logic              rx_fifo_ovr,
    output logic              body_we,
    output logic [ADR_W-1:0]  body_addr,
    output logic [7:0]        body_data,
    output logic              hdr_we,
    output logic [ADR_W-1:0]  hdr_addr,
    output logic [7:0]        hdr_data,
    output logic              load_cur,
    output page_t             load_val,
    output logic              ovf_evt
);

    wr_st_e      st;
    page_t       pos_pg, frm_pg, nxt_pg;
    off_t        pos_off;
    len_t        cnt, len_q;
    rx_stat_t    stat_q;
    logic [HIDX_W-1:0] hidx;

    logic        take, blocked, bad_now;
    page_t       e_pg;
    off_t        e_off;
    len_t        e_cnt;
    rx_stat_t    stat_now;

    always_comb begin
        take     = rx_valid && (st == WR_IDLE || st == WR_BODY);
        e_pg     = (st == WR_IDLE) ? cur : pos_pg;
        e_off    = (st == WR_IDLE) ? off_t'(HDR_N) : pos_off;
        e_cnt    = (st == WR_IDLE) ? '0 : cnt;
        blocked  = (e_pg == bnry);
        ovf_evt  = take && blocked;
        body_we  = take && !blocked;
        body_addr = {e_pg, e_off};
        body_data = rx_data;
        bad_now  = rx_crc_bad || rx_align_bad || rx_fifo_ovr;
        stat_now = '{rsvd: 4'h0, fifo_ovr: rx_fifo_ovr, align_bad: rx_align_bad,
                     crc_bad: rx_crc_bad, intact: !bad_now};
        hdr_we   = (st == WR_HDR);
        hdr_addr = {frm_pg, {(OFF_W-HIDX_W){1'b0}}, hidx};
        case (hidx)
            2'd0:    hdr_data = stat_q;
            2'd1:    hdr_data = nxt_pg;
            2'd2:    hdr_data = len_q[7:0];
            default: hdr_data = len_q[15:8];
        endcase
        load_cur = (st == WR_HDR) && (hidx == HIDX_W'(HDR_N-1));
        load_val = nxt_pg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WR_IDLE;
            pos_pg  <= '0;
            frm_pg  <= '0;
            nxt_pg  <= '0;
            pos_off <= '0;
            cnt     <= '0;
            len_q   <= '0;
            stat_q  <= '0;
            hidx    <= '0;
        end else begin
            case (st)
                WR_IDLE, WR_BODY: begin
                    if (take) begin
                        if (blocked) begin
                            st <= rx_last ? WR_IDLE : WR_SKIP;
                        end else begin
                            if (st == WR_IDLE)
                                frm_pg <= cur;
                            pos_off <= e_off + off_t'(1);
                            pos_pg  <= (e_off == '1) ? page_after(e_pg, lo, hi) : e_pg;
                            cnt     <= e_cnt + len_t'(1);
                            if (rx_last) begin
                                len_q  <= e_cnt + len_t'(1);
                                nxt_pg <= page_after(e_pg, lo, hi);
                                stat_q <= stat_now;
                                hidx   <= '0;
                                st     <= (bad_now && !keep_bad) ? WR_IDLE : WR_HDR;
                            end else begin
                                st <= WR_BODY;
                            end
                        end
                    end
                end
                WR_SKIP: begin
                    if (rx_valid && rx_last)
                        st <= WR_IDLE;
                end
                default: begin
                    hidx <= hidx + 1'b1;
                    if (hidx == HIDX_W'(HDR_N-1))
                        st <= WR_IDLE;
                end
            endcase
        end
    end

    // R4
    hdr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == WR_HDR && hidx != HIDX_W'(HDR_N-1)) |=>
        (st == WR_HDR && hidx == $past(hidx) + 1'b1));

    // R9
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == WR_SKIP) |-> !hdr_we);

endmodule

// File: rtl/rpr_mem_mux.sv
module rpr_mem_mux
    import rx_page_ring_pkg::*;
(
    input  logic             body_we,
    input  logic [ADR_W-1:0] body_addr,
    input  logic [7:0]       body_data,
    input  logic             hdr_we,
    input  logic [ADR_W-1:0] hdr_addr,
    input  logic [7:0]       hdr_data,
    output logic             mem_we,
    output logic [ADR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata
);

    always_comb begin
        mem_we    = body_we || hdr_we;
        mem_addr  = hdr_we ? hdr_addr : body_addr;
        mem_wdata = hdr_we ? hdr_data : body_data;
    end

endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
    import rx_page_ring_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  page_lo,
    input  logic [7:0]  page_hi,
    input  logic        ring_init,
    input  logic        keep_bad,
    input  logic        bnry_we,
    input  logic [7:0]  bnry_wdata,
    input  logic        ovw_clr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_bad,
    input  logic        rx_align_bad,
    input  logic        rx_fifo_ovr,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic [7:0]  cur_page,
    output logic [7:0]  bnry_page,
    output logic        ovw_flag
);

    logic             body_we, hdr_we, load_cur, ovf_evt;
    logic [ADR_W-1:0] body_addr, hdr_addr;
    logic [7:0]       body_data, hdr_data;
    page_t            load_val;

    rpr_ptrs u_ptrs (
        .clk(clk), .rst(rst), .init(ring_init), .lo(page_lo), .hi(page_hi),
        .bnry_we(bnry_we), .bnry_wdata(bnry_wdata),
        .load(load_cur), .load_val(load_val), .ovf_evt(ovf_evt), .ovw_clr(ovw_clr),
        .cur_q(cur_page), .bnry_q(bnry_page), .ovw_q(ovw_flag)
    );

    rpr_writer u_writer (
        .clk(clk), .rst(rst), .cur(cur_page), .bnry(bnry_page),
        .lo(page_lo), .hi(page_hi), .keep_bad(keep_bad),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad), .rx_fifo_ovr(rx_fifo_ovr),
        .body_we(body_we), .body_addr(body_addr), .body_data(body_data),
        .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_data(hdr_data),
        .load_cur(load_cur), .load_val(load_val), .ovf_evt(ovf_evt)
    );

    rpr_mem_mux u_mux (
        .body_we(body_we), .body_addr(body_addr), .body_data(body_data),
        .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_data(hdr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // R3
    mem_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] >= page_lo && mem_addr[15:8] < page_hi));

    // R4
    hdr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(body_we && hdr_we));

endmodule

// File: tb/rx_page_ring_tb.sv
module rx_page_ring_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  page_lo = 8'h10, page_hi = 8'h14;
    logic        ring_init = 1'b0, keep_bad = 1'b0, bnry_we = 1'b0, ovw_clr = 1'b0;
    logic [7:0]  bnry_wdata = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        rx_crc_bad = 1'b0, rx_align_bad = 1'b0, rx_fifo_ovr = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        mem_we, ovw_flag;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_page, bnry_page;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [15:0] exp_a[$];
    logic [7:0]  exp_d[$];
    string       exp_t[$];

    logic [7:0] m_cur, m_bnry;
    bit         m_ovw;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_page_ring u_dut (
        .clk(clk), .rst(rst), .page_lo(page_lo), .page_hi(page_hi),
        .ring_init(ring_init), .keep_bad(keep_bad), .bnry_we(bnry_we),
        .bnry_wdata(bnry_wdata), .ovw_clr(ovw_clr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_crc_bad(rx_crc_bad),
        .rx_align_bad(rx_align_bad), .rx_fifo_ovr(rx_fifo_ovr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .bnry_page(bnry_page), .ovw_flag(ovw_flag)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            checks++;
            if (exp_a.size() == 0) begin
                fails++;
                $display("FAIL R2: actual write %h=%h expected no write", mem_addr, mem_wdata);
            end else begin
                automatic logic [15:0] ea = exp_a.pop_front();
                automatic logic [7:0]  ed = exp_d.pop_front();
                automatic string       et = exp_t.pop_front();
                if (mem_addr !== ea || mem_wdata !== ed) begin
                    fails++;
                    $display("FAIL %s: actual %h=%h expected %h=%h", et, mem_addr, mem_wdata, ea, ed);
                end
            end
        end
    end

    function automatic logic [7:0] nxt(logic [7:0] p);
        return (p + 8'd1 == page_hi) ? page_lo : p + 8'd1;
    endfunction

    task automatic push(logic [15:0] a, logic [7:0] d, string t);
        exp_a.push_back(a);
        exp_d.push_back(d);
        exp_t.push_back(t);
    endtask

    task automatic send_frame(int n, bit crc, bit al, bit fo, bit kb, int seed, string tag);
        logic [7:0] pg = m_cur, last_pg = m_cur, st_pg = m_cur;
        int  off = 4;
        bit  ovf = 1'b0;
        bit  bad = crc | al | fo;
        keep_bad = kb;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            if (!ovf && pg == m_bnry) ovf = 1'b1;
            rx_data = 8'((k * 7 + seed) & 255);
            if (!ovf) begin
                push({pg, 8'(off)}, rx_data, (pg < st_pg) ? "R3" : "R2");
                last_pg = pg;
                off++;
                if (off == 256) begin off = 0; pg = nxt(pg); end
            end
            rx_valid = 1'b1;
            rx_last = (k == n - 1);
            rx_crc_bad = crc; rx_align_bad = al; rx_fifo_ovr = fo;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
        rx_crc_bad = 1'b0; rx_align_bad = 1'b0; rx_fifo_ovr = 1'b0;
        if (ovf) begin
            m_ovw = 1'b1;
        end else if (!(bad && !kb)) begin
            push({st_pg, 8'd0}, {4'h0, fo, al, crc, !bad}, "R7");
            push({st_pg, 8'd1}, nxt(last_pg), "R6");
            push({st_pg, 8'd2}, 8'(n & 255), "R5");
            push({st_pg, 8'd3}, 8'((n >> 8) & 255), "R5");
            m_cur = nxt(last_pg);
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk({tag, " cur_page"}, {8'h0, cur_page}, {8'h0, m_cur});
        chk({tag, " ovw_flag"}, {15'h0, ovw_flag}, {15'h0, m_ovw});
        chk({tag, " pending writes"}, 16'(exp_a.size()), 16'd0);
    endtask

    task automatic set_bnry(logic [7:0] v);
        @(posedge clk); #1;
        bnry_we = 1'b1; bnry_wdata = v;
        @(posedge clk); #1;
        bnry_we = 1'b0;
        m_bnry = v;
        @(negedge clk);
        chk("R10 bnry_page", {8'h0, bnry_page}, {8'h0, v});
    endtask

    task automatic clear_ovw();
        @(posedge clk); #1; ovw_clr = 1'b1;
        @(posedge clk); #1; ovw_clr = 1'b0;
        m_ovw = 1'b0;
        @(negedge clk);
        chk("R9 ovw cleared", {15'h0, ovw_flag}, 16'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cur", {8'h0, cur_page}, 16'h0010);
        chk("R1 reset bnry", {8'h0, bnry_page}, 16'h0013);
        chk("R1 reset ovw", {15'h0, ovw_flag}, 16'h0);
        chk("R1 reset no write", {15'h0, mem_we}, 16'h0);
        m_cur = 8'h10; m_bnry = 8'h13; m_ovw = 1'b0;

        send_frame(64, 0, 0, 0, 0, 3, "R2 short good");
        send_frame(300, 0, 0, 0, 0, 11, "R6 two-page good");
        set_bnry(8'h10);
        send_frame(70, 1, 0, 0, 0, 5, "R8 crc dropped");
        send_frame(70, 1, 1, 0, 1, 9, "R8 kept errored");
        send_frame(30, 0, 0, 0, 0, 1, "R9 first-byte overflow");
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 ovw sticky", {15'h0, ovw_flag}, 16'h1);
        clear_ovw();
        set_bnry(8'h12);
        send_frame(400, 0, 0, 0, 0, 17, "R3 wrapped good");
        set_bnry(8'h11);
        send_frame(900, 0, 0, 0, 0, 23, "R9 overflow after wrap");
        clear_ovw();
        send_frame(20, 0, 0, 1, 1, 2, "R7 fifo overrun kept");

        @(posedge clk); #1 ring_init = 1'b1;
        @(posedge clk); #1 ring_init = 1'b0;
        @(negedge clk);
        chk("R1 init cur", {8'h0, cur_page}, 16'h0010);
        chk("R1 init bnry", {8'h0, bnry_page}, 16'h0013);
        finish_run();
    end

endmodule